// File: doc/BRIEF.md
# FIFO Status and Interrupt Controller

This block sits next to the transmit and receive FIFOs of a serial controller and turns their fill levels and strobes into the words and request lines that software and a DMA engine watch. It reports a five-bit status word and a five-bit raw interrupt word. Three of the raw flags are sticky error flags for transmit overflow, receive overflow and receive underflow. The other two are level conditions taken against programmable watermarks. A mask selects which raw flags reach the masked word and the single interrupt line. Two DMA request lines follow the fill levels against their own programmable levels, each gated by its own enable bit.

Configuration arrives as single-cycle writes with a register select code. Every level-type register ignores a write of a value at or above the FIFO depth and keeps its old contents. Software can therefore find the depth by writing rising values to a threshold register and reading it back until the value stops matching. The FIFO storage and the bus decoding that produces the write strobes lie outside this block.

Top module: `fifo_stat_irq`

## Requirements
- R1: `status` bits are: bit0 `busy`, bit1 transmit full (`tx_level == DEPTH`), bit2 transmit empty (`tx_level == 0`), bit3 receive empty (`rx_level == 0`), bit4 receive full (`rx_level == DEPTH`). All are combinational from the inputs.
- R2: Select codes 0 to 3 write the transmit threshold, receive threshold, transmit DMA level and receive DMA level. A write with `cfg_wdata < DEPTH` is stored at the clock edge. A larger value leaves the register unchanged. The two thresholds are visible on `tx_thr` and `rx_thr`.
- R3: `raw_irq` bit1 (transmit overflow) sets on the clock edge after `tx_push` is sampled while `tx_level == DEPTH`. It stays set until cleared.
- R4: `raw_irq` bit3 (receive overflow) sets after `rx_push` is sampled while `rx_level == DEPTH`. It stays set until cleared.
- R5: `raw_irq` bit2 (receive underflow) sets after `rx_pop` is sampled while `rx_level == 0`. It stays set until cleared.
- R6: Select code 5 is the clear register, using `cfg_wdata[3:0]`. Bit0 clears all three sticky flags. Bit1 clears receive underflow, bit2 clears receive overflow and bit3 clears transmit overflow. Flags whose bits are zero are left alone.
- R7: When a clear write and a new error event for the same flag meet in one cycle, the flag ends up set.
- R8: `raw_irq` bit0 is high while `tx_level` is at or below the transmit threshold. `raw_irq` bit4 is high while `rx_level` is above the receive threshold.
- R9: Select code 4 writes the mask from `cfg_wdata[4:0]`. `masked_irq` is `raw_irq` AND mask, and `irq` is high when any masked bit is high.
- R10: Select code 6 writes the DMA enables: `cfg_wdata[0]` enables receive and `cfg_wdata[1]` enables transmit. `dma_tx_req` is high when transmit DMA is enabled and `tx_level` is at or below the transmit DMA level. `dma_rx_req` is high when receive DMA is enabled and `rx_level` is above the receive DMA level.
- R11: Reset clears every register: thresholds, DMA levels, mask, enables and sticky flags all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Controller busy flag |
| tx_level | input | LW | Transmit FIFO fill level, 0..DEPTH |
| rx_level | input | LW | Receive FIFO fill level, 0..DEPTH |
| tx_push | input | 1 | Write strobe into the transmit FIFO |
| rx_push | input | 1 | Write strobe into the receive FIFO |
| rx_pop | input | 1 | Read strobe from the receive FIFO |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select code |
| cfg_wdata | input | DW | Configuration write data |
| status | output | 5 | Status word |
| raw_irq | output | 5 | Raw interrupt flags |
| masked_irq | output | 5 | Raw flags ANDed with the mask |
| irq | output | 1 | Combined interrupt line |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |
| tx_thr | output | TW | Transmit threshold readback |
| rx_thr | output | TW | Receive threshold readback |

## Verification
The assertions assume that `tx_level` and `rx_level` never exceed `DEPTH`, and that a strobe is sampled against the level presented in the same cycle. They also assume no other writer touches the configuration registers. The stimulus holds every level in 0..DEPTH and changes levels and strobes together on the falling edge. Error strobes are raised only for a single cycle at a chosen level. Out-of-range configuration values go only through `cfg_wdata`, where rejecting them is the behaviour under test.

// File: rtl/fifo_stat_irq.sv
module fifo_stat_irq #(
  parameter int DEPTH = 16,
  parameter int DW = 8,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int TW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_level,
  input  logic          tx_push,
  input  logic          rx_push,
  input  logic          rx_pop,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [4:0]    status,
  output logic [4:0]    raw_irq,
  output logic [4:0]    masked_irq,
  output logic          irq,
  output logic          dma_tx_req,
  output logic          dma_rx_req,
  output logic [TW-1:0] tx_thr,
  output logic [TW-1:0] rx_thr
);

  localparam int NLVL = 4;
  localparam logic [2:0] SEL_MASK = 3'd4;
  localparam logic [2:0] SEL_CLR  = 3'd5;
  localparam logic [2:0] SEL_DMA  = 3'd6;

  logic [TW-1:0] lvl_q [NLVL];
  logic [4:0]    mask_q;
  logic [1:0]    dma_en_q;
  logic          txov_q, rxov_q, rxun_q;

  logic in_range;
  assign in_range = int'(cfg_wdata) < DEPTH;

  // 0: tx threshold, 1: rx threshold, 2: tx dma level, 3: rx dma level
  for (genvar i = 0; i < NLVL; i++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        lvl_q[i] <= '0;
      else if (cfg_we && cfg_sel == 3'(i) && in_range)
        lvl_q[i] <= cfg_wdata[TW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask_q   <= '0;
      dma_en_q <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_MASK) mask_q   <= cfg_wdata[4:0];
      if (cfg_sel == SEL_DMA)  dma_en_q <= cfg_wdata[1:0];
    end

  logic tx_full, tx_empty, rx_full, rx_empty;
  assign tx_full  = tx_level == LW'(DEPTH);
  assign tx_empty = tx_level == '0;
  assign rx_full  = rx_level == LW'(DEPTH);
  assign rx_empty = rx_level == '0;

  logic ev_txov, ev_rxov, ev_rxun;
  assign ev_txov = tx_push && tx_full;
  assign ev_rxov = rx_push && rx_full;
  assign ev_rxun = rx_pop && rx_empty;

  logic clr_hit, clr_txov, clr_rxov, clr_rxun;
  assign clr_hit  = cfg_we && cfg_sel == SEL_CLR;
  assign clr_rxun = clr_hit && (cfg_wdata[0] || cfg_wdata[1]);
  assign clr_rxov = clr_hit && (cfg_wdata[0] || cfg_wdata[2]);
  assign clr_txov = clr_hit && (cfg_wdata[0] || cfg_wdata[3]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      txov_q <= 1'b0;
      rxov_q <= 1'b0;
      rxun_q <= 1'b0;
    end else begin
      txov_q <= ev_txov || (txov_q && !clr_txov);
      rxov_q <= ev_rxov || (rxov_q && !clr_rxov);
      rxun_q <= ev_rxun || (rxun_q && !clr_rxun);
    end

  assign status = {rx_full, rx_empty, tx_empty, tx_full, busy};

  assign raw_irq = {rx_level > LW'(lvl_q[1]), rxov_q, rxun_q, txov_q,
                    tx_level <= LW'(lvl_q[0])};

  assign masked_irq = raw_irq & mask_q;
  assign irq        = |masked_irq;

  assign dma_tx_req = dma_en_q[1] && (tx_level <= LW'(lvl_q[2]));
  assign dma_rx_req = dma_en_q[0] && (rx_level >  LW'(lvl_q[3]));

  assign tx_thr = lvl_q[0];
  assign rx_thr = lvl_q[1];

  p_txov_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_level == LW'(DEPTH)) |=> raw_irq[1]);

  p_rxov_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_level == LW'(DEPTH)) |=> raw_irq[3]);

  p_rxun_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_level == '0) |=> raw_irq[2]);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_irq[1] && !(cfg_we && cfg_sel == SEL_CLR && (cfg_wdata[0] || cfg_wdata[3])))
      |=> raw_irq[1]);

  p_thr_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 3'd0 && int'(cfg_wdata) >= DEPTH) |=> $stable(tx_thr));

  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw_irq != 5'd0));

  p_dma_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_DMA && cfg_wdata[1:0] == 2'b00) |=> !dma_tx_req && !dma_rx_req);

endmodule

// File: tb/sim_fifo_stat_irq.sv
module sim_fifo_stat_irq;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int DW = 8;
  localparam int LW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic busy = 1'b0, tx_push = 1'b0, rx_push = 1'b0, rx_pop = 1'b0, cfg_we = 1'b0;
  logic [LW-1:0] tx_level = '0, rx_level = '0;
  logic [2:0] cfg_sel = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [4:0] status, raw_irq, masked_irq;
  logic irq, dma_tx_req, dma_rx_req;
  logic [TW-1:0] tx_thr, rx_thr;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_stat_irq #(.DEPTH(DEPTH), .DW(DW)) u0 (
    .clk, .rst_n, .busy, .tx_level, .rx_level, .tx_push, .rx_push, .rx_pop,
    .cfg_we, .cfg_sel, .cfg_wdata, .status, .raw_irq, .masked_irq, .irq,
    .dma_tx_req, .dma_rx_req, .tx_thr, .rx_thr);

  // {busy, tx_level, rx_level, expected status, expected raw bit0, expected raw bit4}
  localparam logic [17:0] VEC [6] = '{
    {1'b0, 5'd0,  5'd0,  5'b01100, 1'b1, 1'b0},
    {1'b1, 5'd16, 5'd16, 5'b10011, 1'b0, 1'b1},
    {1'b0, 5'd5,  5'd3,  5'b00000, 1'b0, 1'b1},
    {1'b1, 5'd0,  5'd16, 5'b10101, 1'b1, 1'b1},
    {1'b0, 5'd16, 5'd0,  5'b01010, 1'b0, 1'b0},
    {1'b1, 5'd1,  5'd1,  5'b00001, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    if (which == 0) tx_push = 1'b1;
    if (which == 1) rx_push = 1'b1;
    if (which == 2) rx_pop  = 1'b1;
    @(negedge clk);
    tx_push = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    check("R11 status", 32'(status), 32'b01100);
    check("R11 raw", 32'(raw_irq), 32'b00001);
    check("R11 irq", 32'({masked_irq, irq}), 32'd0);
    check("R11 thr", 32'({tx_thr, rx_thr}), 32'd0);
    check("R11 dma", 32'({dma_tx_req, dma_rx_req}), 32'd0);

    // R1 and R8 table with thresholds at zero
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      busy = VEC[i][17]; tx_level = VEC[i][16:12]; rx_level = VEC[i][11:7];
      #1;
      check("R1 status", 32'(status), 32'(VEC[i][6:2]));
      check("R8 raw0", 32'(raw_irq[0]), 32'(VEC[i][1]));
      check("R8 raw4", 32'(raw_irq[4]), 32'(VEC[i][0]));
    end
    busy = 1'b0; tx_level = 5'd5; rx_level = 5'd5;

    // R2 threshold accept and reject
    wr(3'd0, 8'd7);    check("R2 accept", 32'(tx_thr), 32'd7);
    wr(3'd0, 8'd16);   check("R2 reject depth", 32'(tx_thr), 32'd7);
    wr(3'd0, 8'd15);   check("R2 accept max", 32'(tx_thr), 32'd15);
    wr(3'd0, 8'd200);  check("R2 reject large", 32'(tx_thr), 32'd15);
    wr(3'd1, 8'd3);    check("R2 rx accept", 32'(rx_thr), 32'd3);
    wr(3'd0, 8'd7);

    // R8 level interrupts against thresholds
    @(negedge clk); tx_level = 5'd7; rx_level = 5'd3; #1;
    check("R8 tx at thr", 32'(raw_irq[0]), 32'd1);
    check("R8 rx at thr", 32'(raw_irq[4]), 32'd0);
    @(negedge clk); tx_level = 5'd8; rx_level = 5'd4; #1;
    check("R8 tx above thr", 32'(raw_irq[0]), 32'd0);
    check("R8 rx above thr", 32'(raw_irq[4]), 32'd1);

    // R3 transmit overflow, sticky
    @(negedge clk); tx_level = 5'd15; #1;
    strobe(0);
    check("R3 push not full", 32'(raw_irq[1]), 32'd0);
    @(negedge clk); tx_level = 5'd16; #1;
    strobe(0);
    check("R3 overflow set", 32'(raw_irq[1]), 32'd1);
    @(negedge clk); tx_level = 5'd8; #1;
    check("R3 sticky", 32'(raw_irq[1]), 32'd1);

    // R4 receive overflow
    @(negedge clk); rx_level = 5'd16; #1;
    strobe(1);
    check("R4 overflow set", 32'(raw_irq[3]), 32'd1);

    // R5 receive underflow
    @(negedge clk); rx_level = 5'd0; #1;
    strobe(2);
    check("R5 underflow set", 32'(raw_irq[2]), 32'd1);
    @(negedge clk); rx_level = 5'd2; #1;

    // R9 mask and combined line
    wr(3'd4, 8'b00010);
    check("R9 masked", 32'(masked_irq), 32'b00010);
    check("R9 irq on", 32'(irq), 32'd1);

    // R6 selective and global clear
    wr(3'd5, 8'b0100);
    check("R6 clear rxov", 32'(raw_irq[3:1]), 32'b011);
    wr(3'd5, 8'b0001);
    check("R6 clear all", 32'(raw_irq[3:1]), 32'b000);
    check("R9 irq off", 32'(irq), 32'd0);

    // R7 event wins over clear
    @(negedge clk);
    tx_level = 5'd16; tx_push = 1'b1;
    cfg_we = 1'b1; cfg_sel = 3'd5; cfg_wdata = 8'b1000;
    @(negedge clk);
    tx_push = 1'b0; cfg_we = 1'b0; tx_level = 5'd8;
    #1;
    check("R7 event wins", 32'(raw_irq[1]), 32'd1);
    wr(3'd5, 8'b1000);
    check("R6 clear txov", 32'(raw_irq[1]), 32'd0);

    // R10 DMA requests
    wr(3'd2, 8'd4);
    wr(3'd3, 8'd2);
    wr(3'd2, 8'd20);
    @(negedge clk); tx_level = 5'd4; rx_level = 5'd3; #1;
    check("R10 disabled", 32'({dma_tx_req, dma_rx_req}), 32'd0);
    wr(3'd6, 8'b10);
    check("R10 tx at level", 32'({dma_tx_req, dma_rx_req}), 32'b10);
    @(negedge clk); tx_level = 5'd5; #1;
    check("R10 tx above level", 32'(dma_tx_req), 32'd0);
    wr(3'd6, 8'b01);
    check("R10 rx above level", 32'({dma_tx_req, dma_rx_req}), 32'b01);
    @(negedge clk); rx_level = 5'd2; #1;
    check("R10 rx at level", 32'(dma_rx_req), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule